// File: doc/BRIEF.md
# Dual-Bank Receive Endpoint Buffer

This block buffers host-to-device packets for a single device-side receive endpoint. A serial interface engine fills it one byte per strobe and closes each packet with an end-of-packet pulse that carries a good/bad verdict. A CPU register port drains it. That port has a data view with a read strobe, a count of the bytes not yet read, a read-allowed flag, a received-packet flag and a bank-control flag. The CPU clears the last two with single-cycle pulses.

The endpoint runs with one bank or two, chosen by `cfg_two_bank` while reset is held. Each bank holds up to `DEPTH` bytes. In two-bank mode the engine may fill one bank while the CPU reads the other, and the banks are used strictly in turn. When the CPU releases its bank by clearing the bank-control flag, and the other bank already holds a complete good packet, ownership moves to that bank on the same clock edge. A packet ending bad is dropped and its bank stays free. A packet that starts while the next fill bank is occupied is refused with a not-ready indication.

Top module: `rx_ep_buffer`

## Requirements
- R1: After reset the flags `cpu_rxpkt`, `cpu_bankctl`, `cpu_rdok` and `sie_nak` are 0, `cpu_count` is 0 and `cpu_rdata` is 0.
- R2: A packet that ends with `sie_eop`=1 and `sie_good`=1 into a free bank is handed to the CPU when the CPU owns no bank. `cpu_rxpkt` and `cpu_bankctl` become 1 and `cpu_count` equals the packet length.
- R3: While the CPU owns a bank, `cpu_rdata` shows the oldest unread byte in arrival order. Each `cpu_rd` pulse moves to the next byte and lowers `cpu_count` by one. `cpu_rdok` is 1 exactly while `cpu_count` is non-zero.
- R4: With no unread byte, `cpu_rdata` is 0 and a `cpu_rd` pulse changes neither the data nor the count.
- R5: A packet ending with `sie_good`=0 sets no flag, and its bank stays free for the next packet.
- R6: If the bank due to be filled next is occupied, `sie_nak` is 1 while the engine is idle and throughout a packet that started in that state. All bytes of that packet are discarded.
- R7: In two-bank mode a packet can be accepted into the second bank while the CPU still owns the first. The banks fill and drain alternately.
- R8: A `cpu_clr_bankctl` pulse releases the owned bank. If the other bank holds a complete packet, `cpu_rxpkt` and `cpu_bankctl` are 1 on the very next cycle, with `cpu_count` showing that packet's length. Otherwise both flags are 0. `cpu_bankctl` falls only on such a pulse.
- R9: In one-bank mode a second packet is refused (`sie_nak`=1) for as long as the CPU owns the single bank.
- R10: A `cpu_clr_rxpkt` pulse clears only `cpu_rxpkt`. `cpu_bankctl` stays 1 and the bank stays owned and readable. `cpu_rxpkt` is never 1 while `cpu_bankctl` is 0.
- R11: Bytes beyond `DEPTH` in one packet are dropped, so `cpu_count` never exceeds `DEPTH`.
- R12: A good packet of zero bytes is handed over with `cpu_rxpkt`=1, `cpu_count`=0 and `cpu_rdok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_two_bank | input | 1 | 1 = two banks, 0 = one bank; change only during reset |
| sie_byte_vld | input | 1 | Byte strobe from the serial engine |
| sie_byte | input | DW | Received byte |
| sie_eop | input | 1 | End-of-packet pulse; may coincide with a final byte |
| sie_good | input | 1 | Packet verdict, sampled with `sie_eop` |
| sie_nak | output | 1 | Not ready: current or next packet is refused |
| cpu_rd | input | 1 | Data read strobe |
| cpu_clr_rxpkt | input | 1 | Pulse that clears the received-packet flag |
| cpu_clr_bankctl | input | 1 | Pulse that releases the owned bank |
| cpu_rdata | output | DW | Oldest unread byte, 0 when none |
| cpu_count | output | $clog2(DEPTH+1) | Unread bytes in the owned bank |
| cpu_rdok | output | 1 | Read allowed: unread bytes remain |
| cpu_rxpkt | output | 1 | Received-packet flag |
| cpu_bankctl | output | 1 | Bank-control flag: CPU owns a bank |

## Verification
The checker watches several invariants on every cycle. The count never exceeds the bank depth, and each read of a non-empty bank lowers the count by exactly one. An empty view returns zero. The received-packet flag never stands without the bank-control flag, and the bank-control flag only falls after a release pulse. With one bank, not-ready holds while the CPU owns that bank. Some behaviour can only be shown by the bench's packet scenarios against its own model of the two banks:
- the byte order and values that come out;
- dropping of bad and refused packets;
- strict alternation between the banks;
- the same-edge hand-over to an already filled bank;
- saturation at the depth limit.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int NBANK = 2;
    localparam int BSEL_W = 1;
endpackage

// File: rtl/rxb_bank_ram.sv
module rxb_bank_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/rxb_rd_sel.sv
module rxb_rd_sel #(
    parameter int NB = 2,
    parameter int DW = 8,
    parameter int SW = 1
) (
    input  logic [NB-1:0][DW-1:0] bank_data,
    input  logic [SW-1:0]         sel,
    input  logic                  valid,
    output logic [DW-1:0]         rdata
);
    always_comb begin
        rdata = '0;
        if (valid) begin
            rdata = bank_data[sel];
        end
    end
endmodule

// File: rtl/rx_ep_buffer.sv
module rx_ep_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_two_bank,
    input  logic          sie_byte_vld,
    input  logic [DW-1:0] sie_byte,
    input  logic          sie_eop,
    input  logic          sie_good,
    output logic          sie_nak,
    input  logic          cpu_rd,
    input  logic          cpu_clr_rxpkt,
    input  logic          cpu_clr_bankctl,
    output logic [DW-1:0] cpu_rdata,
    output logic [CW-1:0] cpu_count,
    output logic          cpu_rdok,
    output logic          cpu_rxpkt,
    output logic          cpu_bankctl
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [BSEL_W-1:0]          fill_bk;
        logic [BSEL_W-1:0]          cpu_bk;
        logic [NBANK-1:0]           full;
        logic [NBANK-1:0][CW-1:0]   cnt;
        logic [CW-1:0]              wptr;
        logic                       in_pkt;
        logic                       drop;
        logic                       own;
        logic                       rxpkt;
        logic                       bankctl;
        logic [CW-1:0]              rptr;
    } ep_state_t;

    ep_state_t st_d, st_q;

    logic                   eff_drop;
    logic [CW-1:0]          wbase;
    logic                   wr_hit;
    logic [CW-1:0]          new_len;
    logic [BSEL_W-1:0]      next_bk;
    logic                   unread;
    logic [NBANK-1:0][DW-1:0] bank_rd;

    always_comb begin
        st_d     = st_q;
        eff_drop = st_q.in_pkt ? st_q.drop : st_q.full[st_q.fill_bk];
        wbase    = st_q.in_pkt ? st_q.wptr : '0;
        wr_hit   = sie_byte_vld && !eff_drop && (wbase < CW'(DEPTH));
        new_len  = wbase + CW'(wr_hit);
        next_bk  = cfg_two_bank ? ~st_q.cpu_bk : st_q.cpu_bk;
        unread   = st_q.own && (st_q.rptr != st_q.cnt[st_q.cpu_bk]);

        // serial side
        if (sie_eop) begin
            st_d.in_pkt = 1'b0;
            st_d.drop   = 1'b0;
            st_d.wptr   = '0;
            if (sie_good && !eff_drop) begin
                st_d.full[st_q.fill_bk] = 1'b1;
                st_d.cnt[st_q.fill_bk]  = new_len;
                if (cfg_two_bank) begin
                    st_d.fill_bk = ~st_q.fill_bk;
                end
            end
        end else if (sie_byte_vld) begin
            st_d.in_pkt = 1'b1;
            st_d.drop   = eff_drop;
            st_d.wptr   = new_len;
        end

        // CPU side
        if (cpu_clr_rxpkt) begin
            st_d.rxpkt = 1'b0;
        end
        if (st_q.own && cpu_clr_bankctl) begin
            st_d.full[st_q.cpu_bk] = 1'b0;
            st_d.cpu_bk  = next_bk;
            st_d.rptr    = '0;
            st_d.own     = 1'b0;
            st_d.rxpkt   = 1'b0;
            st_d.bankctl = 1'b0;
            if (cfg_two_bank && st_q.full[next_bk]) begin
                st_d.own     = 1'b1;
                st_d.rxpkt   = 1'b1;
                st_d.bankctl = 1'b1;
            end
        end else if (!st_q.own && st_q.full[st_q.cpu_bk]) begin
            st_d.own     = 1'b1;
            st_d.rxpkt   = 1'b1;
            st_d.bankctl = 1'b1;
            st_d.rptr    = '0;
        end else if (cpu_rd && unread) begin
            st_d.rptr = st_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rxb_bank_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
            .clk     (clk),
            .wr_en   (wr_hit && (st_q.fill_bk == BSEL_W'(b))),
            .wr_addr (wbase[AW-1:0]),
            .wr_data (sie_byte),
            .rd_addr (st_q.rptr[AW-1:0]),
            .rd_data (bank_rd[b])
        );
    end

    rxb_rd_sel #(.NB(NBANK), .DW(DW), .SW(BSEL_W)) u_rd_sel (
        .bank_data (bank_rd),
        .sel       (st_q.cpu_bk),
        .valid     (unread),
        .rdata     (cpu_rdata)
    );

    assign sie_nak     = eff_drop;
    assign cpu_count   = st_q.own ? (st_q.cnt[st_q.cpu_bk] - st_q.rptr) : '0;
    assign cpu_rdok    = unread;
    assign cpu_rxpkt   = st_q.rxpkt;
    assign cpu_bankctl = st_q.bankctl;
endmodule

// File: rtl/rx_ep_buffer_chk.sv
module rx_ep_buffer_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_two_bank,
    input logic          sie_nak,
    input logic          cpu_rd,
    input logic          cpu_clr_bankctl,
    input logic [DW-1:0] cpu_rdata,
    input logic [CW-1:0] cpu_count,
    input logic          cpu_rxpkt,
    input logic          cpu_bankctl
);
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_count <= CW'(DEPTH));

    a_r3_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_count != '0 && !cpu_clr_bankctl) |=>
        (cpu_count == $past(cpu_count) - 1'b1));

    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_count == '0) |-> (cpu_rdata == '0));

    a_r10_rx_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rxpkt |-> cpu_bankctl);

    a_r8_ctl_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_bankctl) |-> $past(cpu_clr_bankctl));

    a_r9_single_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_two_bank && cpu_bankctl) |-> sie_nak);
endmodule

bind rx_ep_buffer rx_ep_buffer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_two_bank    (cfg_two_bank),
    .sie_nak         (sie_nak),
    .cpu_rd          (cpu_rd),
    .cpu_clr_bankctl (cpu_clr_bankctl),
    .cpu_rdata       (cpu_rdata),
    .cpu_count       (cpu_count),
    .cpu_rxpkt       (cpu_rxpkt),
    .cpu_bankctl     (cpu_bankctl)
);

// File: tb/rx_ep_buffer_bench.sv
module rx_ep_buffer_bench;
    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_two_bank = 1'b1;
    logic sie_byte_vld = 1'b0;
    logic [DW-1:0] sie_byte = '0;
    logic sie_eop = 1'b0;
    logic sie_good = 1'b0;
    logic sie_nak;
    logic cpu_rd = 1'b0;
    logic cpu_clr_rxpkt = 1'b0;
    logic cpu_clr_bankctl = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic [CW-1:0] cpu_count;
    logic cpu_rdok, cpu_rxpkt, cpu_bankctl;

    always #2.5 clk = ~clk;

    rx_ep_buffer #(.DEPTH(DEPTH), .DW(DW)) u_rx_ep_buffer (
        .clk(clk), .rst_n(rst_n), .cfg_two_bank(cfg_two_bank),
        .sie_byte_vld(sie_byte_vld), .sie_byte(sie_byte), .sie_eop(sie_eop),
        .sie_good(sie_good), .sie_nak(sie_nak), .cpu_rd(cpu_rd),
        .cpu_clr_rxpkt(cpu_clr_rxpkt), .cpu_clr_bankctl(cpu_clr_bankctl),
        .cpu_rdata(cpu_rdata), .cpu_count(cpu_count), .cpu_rdok(cpu_rdok),
        .cpu_rxpkt(cpu_rxpkt), .cpu_bankctl(cpu_bankctl)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model of the banks
    bit        m_two;
    bit        m_full [2];
    int        m_len  [2];
    logic [7:0] m_dat [2][DEPTH];
    int        m_fill, m_cpu;

    function automatic int sat_len(input int len);
        return (len > DEPTH) ? DEPTH : len;
    endfunction

    function automatic bit any_full();
        return m_full[0] || m_full[1];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input bit two);
        rst_n = 1'b0;
        cfg_two_bank = two;
        m_two = two;
        m_full[0] = 0; m_full[1] = 0;
        m_fill = 0; m_cpu = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int len, input bit good);
        bit exp_nak;
        bit keep;
        exp_nak = m_full[m_fill];
        keep = !exp_nak && good;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            sie_byte_vld = 1'b1;
            sie_byte = DW'($urandom);
            check("R6 nak during packet", sie_nak, exp_nak);
            if (keep && i < DEPTH) m_dat[m_fill][i] = sie_byte;
        end
        @(negedge clk);
        sie_byte_vld = 1'b0;
        sie_eop = 1'b1;
        sie_good = good;
        if (len == 0) check("R6 nak at zero-length start", sie_nak, exp_nak);
        @(negedge clk);
        sie_eop = 1'b0;
        sie_good = 1'b0;
        if (keep) begin
            m_full[m_fill] = 1;
            m_len[m_fill] = sat_len(len);
            if (m_two) m_fill ^= 1;
        end
    endtask

    task automatic drain();
        int n;
        @(negedge clk);
        n = m_len[m_cpu];
        check("R2 rxpkt set", cpu_rxpkt, 1);
        check("R2 bankctl set", cpu_bankctl, 1);
        check("R2 count", cpu_count, n);
        for (int i = 0; i < n; i++) begin
            check("R3 data order", cpu_rdata, m_dat[m_cpu][i]);
            check("R3 rdok while unread", cpu_rdok, 1);
            cpu_rd = 1'b1;
            @(negedge clk);
            cpu_rd = 1'b0;
        end
        check("R3 count at end", cpu_count, 0);
        check("R3 rdok drops", cpu_rdok, 0);
        cpu_rd = 1'b1;
        check("R4 empty data", cpu_rdata, 0);
        @(negedge clk);
        cpu_rd = 1'b0;
        check("R4 empty read count", cpu_count, 0);
        check("R4 empty read data", cpu_rdata, 0);
        cpu_clr_rxpkt = 1'b1;
        @(negedge clk);
        cpu_clr_rxpkt = 1'b0;
        check("R10 rxpkt cleared", cpu_rxpkt, 0);
        check("R10 bankctl kept", cpu_bankctl, 1);
        cpu_clr_bankctl = 1'b1;
        @(negedge clk);
        cpu_clr_bankctl = 1'b0;
        m_full[m_cpu] = 0;
        if (m_two) m_cpu ^= 1;
        if (m_full[m_cpu]) begin
            check("R8 immediate rxpkt", cpu_rxpkt, 1);
            check("R8 immediate bankctl", cpu_bankctl, 1);
            check("R8 next count", cpu_count, m_len[m_cpu]);
        end else begin
            check("R8 rxpkt after release", cpu_rxpkt, 0);
            check("R8 bankctl after release", cpu_bankctl, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        do_reset(1'b1);
        check("R1 rxpkt", cpu_rxpkt, 0);
        check("R1 bankctl", cpu_bankctl, 0);
        check("R1 count", cpu_count, 0);
        check("R1 nak", sie_nak, 0);
        check("R1 rdata", cpu_rdata, 0);
        check("R1 rdok", cpu_rdok, 0);

        // R7: second bank fills while CPU owns the first
        send(5, 1'b1);
        @(negedge clk);
        check("R7 first owned", cpu_bankctl, 1);
        check("R7 nak free", sie_nak, 0);
        send(7, 1'b1);
        check("R7 still first count", cpu_count, 5);
        send(3, 1'b1);          // both busy: refused (R6)
        check("R6 nak held idle", sie_nak, 1);
        drain();                // R8 hand-over inside
        drain();

        // R5: bad packet dropped
        send(4, 1'b0);
        repeat (2) @(negedge clk);
        check("R5 no rxpkt", cpu_rxpkt, 0);
        check("R5 bank free", sie_nak, 0);
        send(3, 1'b1);
        drain();

        // R11: overflow saturates
        send(70, 1'b1);
        @(negedge clk);
        check("R11 count saturates", cpu_count, DEPTH);
        drain();

        // R12: zero-length packet
        send(0, 1'b1);
        @(negedge clk);
        check("R12 rxpkt", cpu_rxpkt, 1);
        check("R12 count", cpu_count, 0);
        check("R12 rdok", cpu_rdok, 0);
        drain();

        // R9: single bank
        do_reset(1'b0);
        send(3, 1'b1);
        @(negedge clk);
        check("R9 nak single", sie_nak, 1);
        send(2, 1'b1);
        drain();
        check("R9 nak released", sie_nak, 0);
        send(2, 1'b1);
        drain();

        // constrained random
        for (int it = 0; it < 400; it++) begin
            if (it % 100 == 0) do_reset(it % 200 == 0);
            if (any_full() && ($urandom % 2 == 0)) begin
                drain();
            end else begin
                send(int'($urandom % 72), ($urandom % 5) != 0);
            end
        end
        while (any_full()) drain();

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule